// File: doc/BRIEF.md
# Row Buffer Controller with Selective Segment Writeback

This block manages the row buffer of one memory bank whose sense amplifiers are separate from the buffer, as in a non-volatile main memory. Opening a row copies the array row into the buffer after a fixed read latency. Reads are served from the buffer and never restore the array. Writes update the buffered copy and mark the touched segment as modified. Each segment of a row (64 bytes at the default width) has its own dirty bit.

When the row is closed, or when a new activate wants to evict it, only the modified segments are written back. A clean row closes with no array traffic. A dirty row is drained one array write per dirty segment, lowest index first, with a fixed write latency per segment. A mode input switches writes to bypass: each write goes straight to the array through the write port and never allocates the buffer. If a bypass write targets the open row, it also refreshes the buffered copy so that later reads see the new data.

Top module: `rowbuf_wb`

## Requirements
- R1: An activate accepted at a clock edge pulses `arrRdEn` for exactly the following cycle with `arrRow` equal to the requested row. `busy` stays high for `RD_LAT` cycles. The row is then open, with all dirty bits clear, and no array write occurs.
- R2: A read (`reqOp`=1) to an open row sets `rspValid` in the cycle after acceptance, carrying the buffered segment `reqSeg`, with no array access. A read or non-bypass write with no open row has no effect on responses, dirty bits or the array.
- R3: A non-bypass write (`reqOp`=2) to an open row replaces segment `reqSeg` in the buffer and sets bit `reqSeg` of `segDirty` from the next cycle on.
- R4: `rowDirty` is high exactly when at least one bit of `segDirty` is set.
- R5: A precharge (`reqOp`=3) of a row with no dirty segment drops `rowOpen` in the next cycle, with no array write and no busy period.
- R6: A precharge of a dirty row issues one array write per dirty segment and none for clean segments. The writes go in ascending segment order, with `arrWrSeg` naming the segment, `arrRow` the open row and `arrWrData` the buffered data. The first `arrWrEn` pulse comes in the cycle after acceptance, and further pulses follow every `WR_LAT` cycles.
- R7: A segment's dirty bit clears when its array write completes. `busy` stays high for exactly (number of dirty segments) x `WR_LAT` cycles, and the row closes when it drops.
- R8: An activate (`reqOp`=0) is not accepted while the open row has dirty segments. The block first drains those segments with the same writeback sequence and then accepts the activate.
- R9: With `bypassMode` high, a write pulses `arrWrEn` in the next cycle for row `reqRow`, segment `reqSeg`, and holds `busy` for `WR_LAT` cycles. It never allocates the buffer. If it hits the open row, it updates the buffered segment and leaves that segment's dirty bit clear.
- R10: `reqReady` is low in every cycle in which `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypassMode | input | 1 | Writes go straight to the array when high |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| reqRow | input | ROW_W | Row for activate and bypass write |
| reqSeg | input | $clog2(NUM_SEG) | Segment index for read and write |
| reqData | input | SEG_W | Write data |
| reqReady | output | 1 | Request accepted at this edge when valid |
| rspValid | output | 1 | Read data valid |
| rspData | output | SEG_W | Read data |
| arrRdEn | output | 1 | Array row read strobe |
| arrWrEn | output | 1 | Array segment write strobe |
| arrRow | output | ROW_W | Array row address |
| arrWrSeg | output | $clog2(NUM_SEG) | Segment select for the array write |
| arrWrData | output | SEG_W | Array write data |
| arrRdData | input | NUM_SEG*SEG_W | Whole row from the array, sampled at the end of the read latency |
| busy | output | 1 | Fill, writeback or bypass write in progress |
| rowOpen | output | 1 | A row is held in the buffer |
| openRow | output | ROW_W | Index of the buffered row |
| segDirty | output | NUM_SEG | Per-segment modified flags |
| rowDirty | output | 1 | Any segment modified |

## Verification
The outputs fall into three timing classes. Read responses, array strobes and dirty-bit updates appear one cycle after the accepting edge. The row opens `RD_LAT` cycles after an activate. A writeback ends `WR_LAT` cycles per dirty segment after the precharge. Every request is issued in a task that returns just after the accepting edge, and each single-cycle result is sampled at the following falling edge. Busy periods are measured by counting falling edges until `busy` drops, and the count is compared with the latency times the number of dirty segments. The sweep visits every dirty pattern of a four-segment row, and a bench-side array model checks both the write order and the contents the array ends up holding.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } reqOp_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic openCap;   // latch new row index, invalidate buffer
    logic loadRow;   // capture array row into buffer
    logic bufWr;     // write request data into buffer segment
    logic setDirty;  // mark request segment modified
    logic clrDirty;  // clear request segment flag (bypass hit)
    logic wbCap;     // latch next dirty segment for writeback
    logic bypCap;    // latch bypass write
    logic wbDone;    // current writeback segment finished
    logic closeRow;  // mark buffer empty
    logic rdRsp;     // launch read response
  } strobe_t;

endpackage

// File: rtl/rowbuf_lowsel.sv
module rowbuf_lowsel #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan down so the last hit is the smallest index
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rowbuf_dp.sv
module rowbuf_dp
  import rowbuf_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 512,
  localparam int IW = $clog2(NUM_SEG),
  localparam int RB = NUM_SEG * SEG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [IW-1:0]    reqSeg,
  input  logic [SEG_W-1:0] reqData,
  input  logic [RB-1:0]    arrRdData,
  output logic             rspValid,
  output logic [SEG_W-1:0] rspData,
  output logic [ROW_W-1:0] arrRow,
  output logic [IW-1:0]    arrWrSeg,
  output logic [SEG_W-1:0] arrWrData,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow,
  output logic [NUM_SEG-1:0] segDirty,
  output logic             dirtyAny,
  output logic             remainAny,
  output logic             hit
);
  localparam logic [NUM_SEG-1:0] ONE = NUM_SEG'(1);

  logic [SEG_W-1:0]   segBuf [NUM_SEG];
  logic [NUM_SEG-1:0] dirtyQ;
  logic               rowOpenQ;
  logic [ROW_W-1:0]   openRowQ;
  logic [ROW_W-1:0]   arrRowQ;
  logic [IW-1:0]      wrSegQ;
  logic [SEG_W-1:0]   wrDataQ;
  logic               rspValidQ;
  logic [SEG_W-1:0]   rspDataQ;

  logic [NUM_SEG-1:0] remain;
  logic [NUM_SEG-1:0] selSrc;
  logic [IW-1:0]      nextSeg;

  assign remain = dirtyQ & ~(ONE << wrSegQ);
  // when a segment finishes in the same cycle, pick from what remains
  assign selSrc = stb.wbDone ? remain : dirtyQ;

  rowbuf_lowsel #(.N(NUM_SEG)) u_lowsel (
    .req (selSrc),
    .idx (nextSeg)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (stb.loadRow) begin
        segBuf[g] <= arrRdData[g*SEG_W +: SEG_W];
      end else if (stb.bufWr && reqSeg == IW'(g)) begin
        segBuf[g] <= reqData;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dirtyQ[g] <= 1'b0;
      end else if (stb.loadRow) begin
        dirtyQ[g] <= 1'b0;
      end else if (stb.setDirty && reqSeg == IW'(g)) begin
        dirtyQ[g] <= 1'b1;
      end else if (stb.clrDirty && reqSeg == IW'(g)) begin
        dirtyQ[g] <= 1'b0;
      end else if (stb.wbDone && wrSegQ == IW'(g)) begin
        dirtyQ[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowOpenQ <= 1'b0;
    end else if (stb.openCap || stb.closeRow) begin
      rowOpenQ <= 1'b0;
    end else if (stb.loadRow) begin
      rowOpenQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      openRowQ <= '0;
    end else if (stb.openCap) begin
      openRowQ <= reqRow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arrRowQ <= '0;
      wrSegQ  <= '0;
      wrDataQ <= '0;
    end else if (stb.openCap) begin
      arrRowQ <= reqRow;
    end else if (stb.bypCap) begin
      arrRowQ <= reqRow;
      wrSegQ  <= reqSeg;
      wrDataQ <= reqData;
    end else if (stb.wbCap) begin
      arrRowQ <= openRowQ;
      wrSegQ  <= nextSeg;
      wrDataQ <= segBuf[nextSeg];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValidQ <= 1'b0;
      rspDataQ  <= '0;
    end else begin
      rspValidQ <= stb.rdRsp;
      if (stb.rdRsp) rspDataQ <= segBuf[reqSeg];
    end
  end

  assign rspValid  = rspValidQ;
  assign rspData   = rspDataQ;
  assign arrRow    = arrRowQ;
  assign arrWrSeg  = wrSegQ;
  assign arrWrData = wrDataQ;
  assign rowOpen   = rowOpenQ;
  assign openRow   = openRowQ;
  assign segDirty  = dirtyQ;
  assign dirtyAny  = |dirtyQ;
  assign remainAny = |remain;
  assign hit       = rowOpenQ && (reqRow == openRowQ);

endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
  import rowbuf_pkg::*;
#(
  parameter int RD_LAT = 4,
  parameter int WR_LAT = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       bypassMode,
  input  logic       rowOpen,
  input  logic       dirtyAny,
  input  logic       remainAny,
  input  logic       hit,
  output logic       reqReady,
  output logic       busy,
  output logic       arrRdEn,
  output logic       arrWrEn,
  output strobe_t    stb
);
  localparam int MAXL = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_LAT - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WB, S_BYP} state_e;

  state_e        stQ, stD;
  logic [CW-1:0] cntQ, cntD;
  logic          closeQ, closeD;
  logic          blockAct;
  logic          take;

  assign blockAct = (reqOp == OP_ACT) && rowOpen && dirtyAny;
  assign reqReady = (stQ == S_IDLE) && !blockAct;
  assign take     = reqValid && reqReady;

  always_comb begin
    stb    = '0;
    stD    = stQ;
    cntD   = cntQ;
    closeD = closeQ;
    unique case (stQ)
      S_IDLE: begin
        cntD = '0;
        if (take) begin
          unique case (reqOp)
            OP_ACT: begin
              stb.openCap = 1'b1;
              stD = S_FILL;
            end
            OP_RD: begin
              if (rowOpen) stb.rdRsp = 1'b1;
            end
            OP_WR: begin
              if (bypassMode) begin
                stb.bypCap = 1'b1;
                if (hit) begin
                  stb.bufWr    = 1'b1;
                  stb.clrDirty = 1'b1;
                end
                stD = S_BYP;
              end else if (rowOpen) begin
                stb.bufWr    = 1'b1;
                stb.setDirty = 1'b1;
              end
            end
            OP_PRE: begin
              if (rowOpen) begin
                if (dirtyAny) begin
                  stb.wbCap = 1'b1;
                  closeD = 1'b1;
                  stD = S_WB;
                end else begin
                  stb.closeRow = 1'b1;
                end
              end
            end
            default: ;
          endcase
        end else if (reqValid && blockAct) begin
          // eviction: drain dirty segments, keep the row until the activate
          stb.wbCap = 1'b1;
          closeD = 1'b0;
          stD = S_WB;
        end
      end
      S_FILL: begin
        if (cntQ == RD_LAST) begin
          stb.loadRow = 1'b1;
          stD = S_IDLE;
          cntD = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      S_WB: begin
        if (cntQ == WR_LAST) begin
          stb.wbDone = 1'b1;
          cntD = '0;
          if (remainAny) begin
            stb.wbCap = 1'b1;
          end else begin
            if (closeQ) stb.closeRow = 1'b1;
            closeD = 1'b0;
            stD = S_IDLE;
          end
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      S_BYP: begin
        if (cntQ == WR_LAST) begin
          stD = S_IDLE;
          cntD = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      default: stD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ    <= S_IDLE;
      cntQ   <= '0;
      closeQ <= 1'b0;
    end else begin
      stQ    <= stD;
      cntQ   <= cntD;
      closeQ <= closeD;
    end
  end

  assign busy    = (stQ != S_IDLE);
  assign arrRdEn = (stQ == S_FILL) && (cntQ == '0);
  assign arrWrEn = ((stQ == S_WB) || (stQ == S_BYP)) && (cntQ == '0);

endmodule

// File: rtl/rowbuf_wb.sv
module rowbuf_wb
  import rowbuf_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 512,
  parameter int RD_LAT  = 4,
  parameter int WR_LAT  = 6,
  localparam int IW = $clog2(NUM_SEG),
  localparam int RB = NUM_SEG * SEG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bypassMode,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [ROW_W-1:0]   reqRow,
  input  logic [IW-1:0]      reqSeg,
  input  logic [SEG_W-1:0]   reqData,
  output logic               reqReady,
  output logic               rspValid,
  output logic [SEG_W-1:0]   rspData,
  output logic               arrRdEn,
  output logic               arrWrEn,
  output logic [ROW_W-1:0]   arrRow,
  output logic [IW-1:0]      arrWrSeg,
  output logic [SEG_W-1:0]   arrWrData,
  input  logic [RB-1:0]      arrRdData,
  output logic               busy,
  output logic               rowOpen,
  output logic [ROW_W-1:0]   openRow,
  output logic [NUM_SEG-1:0] segDirty,
  output logic               rowDirty
);
  strobe_t stb;
  logic    dirtyAny;
  logic    remainAny;
  logic    hit;

  rowbuf_ctrl #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .bypassMode (bypassMode),
    .rowOpen    (rowOpen),
    .dirtyAny   (dirtyAny),
    .remainAny  (remainAny),
    .hit        (hit),
    .reqReady   (reqReady),
    .busy       (busy),
    .arrRdEn    (arrRdEn),
    .arrWrEn    (arrWrEn),
    .stb        (stb)
  );

  rowbuf_dp #(.ROW_W(ROW_W), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .reqRow    (reqRow),
    .reqSeg    (reqSeg),
    .reqData   (reqData),
    .arrRdData (arrRdData),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .arrRow    (arrRow),
    .arrWrSeg  (arrWrSeg),
    .arrWrData (arrWrData),
    .rowOpen   (rowOpen),
    .openRow   (openRow),
    .segDirty  (segDirty),
    .dirtyAny  (dirtyAny),
    .remainAny (remainAny),
    .hit       (hit)
  );

  assign rowDirty = dirtyAny;

endmodule

// File: rtl/rowbuf_wb_chk.sv
module rowbuf_wb_chk #(
  parameter int ROW_W   = 14,
  parameter int NUM_SEG = 4,
  localparam int IW = $clog2(NUM_SEG)
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic [1:0]         reqOp,
  input logic               reqReady,
  input logic               arrRdEn,
  input logic               arrWrEn,
  input logic [ROW_W-1:0]   arrRow,
  input logic [IW-1:0]      arrWrSeg,
  input logic               busy,
  input logic               rowOpen,
  input logic [ROW_W-1:0]   openRow,
  input logic [NUM_SEG-1:0] segDirty
);
  localparam logic [NUM_SEG-1:0] ONE = NUM_SEG'(1);

  // R10
  ready_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !reqReady);

  // R1
  fill_closed_chk: assert property (@(posedge clk) disable iff (rst)
    arrRdEn |-> (busy && !rowOpen && !arrWrEn));

  // R7
  no_new_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((segDirty & ~$past(segDirty)) == '0));

  // R6
  ascending_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (arrWrEn && rowOpen && arrRow == openRow && segDirty[arrWrSeg])
      |-> ((segDirty & ((ONE << arrWrSeg) - ONE)) == '0));

  // R8
  act_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqOp == 2'd0) |-> (segDirty == '0 || !rowOpen));

  // R5
  close_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rowOpen) |-> (segDirty == '0));

endmodule

bind rowbuf_wb rowbuf_wb_chk #(.ROW_W(ROW_W), .NUM_SEG(NUM_SEG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqReady (reqReady),
  .arrRdEn  (arrRdEn),
  .arrWrEn  (arrWrEn),
  .arrRow   (arrRow),
  .arrWrSeg (arrWrSeg),
  .busy     (busy),
  .rowOpen  (rowOpen),
  .openRow  (openRow),
  .segDirty (segDirty)
);

// File: tb/rowbuf_wb_bench.sv
module rowbuf_wb_bench;
  localparam int ROW_W = 3;
  localparam int NSEG  = 4;
  localparam int SW    = 16;
  localparam int RDL   = 3;
  localparam int WRL   = 5;
  localparam int NROW  = 8;

  logic clk = 1'b0;
  logic rst;
  logic bypassMode;
  logic reqValid;
  logic [1:0] reqOp;
  logic [ROW_W-1:0] reqRow;
  logic [1:0] reqSeg;
  logic [SW-1:0] reqData;
  logic reqReady, rspValid, arrRdEn, arrWrEn, busy, rowOpen, rowDirty;
  logic [SW-1:0] rspData, arrWrData;
  logic [ROW_W-1:0] arrRow, openRow;
  logic [1:0] arrWrSeg;
  logic [NSEG*SW-1:0] arrRdData;
  logic [NSEG-1:0] segDirty;

  always #5 clk = ~clk;

  rowbuf_wb #(.ROW_W(ROW_W), .NUM_SEG(NSEG), .SEG_W(SW), .RD_LAT(RDL), .WR_LAT(WRL)) u_rowbuf_wb (
    .clk(clk), .rst(rst), .bypassMode(bypassMode), .reqValid(reqValid), .reqOp(reqOp),
    .reqRow(reqRow), .reqSeg(reqSeg), .reqData(reqData), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .arrRdEn(arrRdEn), .arrWrEn(arrWrEn),
    .arrRow(arrRow), .arrWrSeg(arrWrSeg), .arrWrData(arrWrData), .arrRdData(arrRdData),
    .busy(busy), .rowOpen(rowOpen), .openRow(openRow), .segDirty(segDirty), .rowDirty(rowDirty)
  );

  function automatic logic [SW-1:0] pat(int r, int s);
    return SW'(16'hA000 | (r << 4) | s);
  endfunction

  // array model
  logic [SW-1:0] mem [NROW][NSEG];
  logic [SW-1:0] mdl [NROW][NSEG];
  int wrCnt, rdCnt;
  logic [31:0] wrLog;

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NROW; r++)
        for (int s = 0; s < NSEG; s++) mem[r][s] <= pat(r, s);
      wrCnt <= 0;
      rdCnt <= 0;
      wrLog <= '0;
    end else begin
      if (arrWrEn) begin
        mem[arrRow][arrWrSeg] <= arrWrData;
        wrCnt <= wrCnt + 1;
        wrLog <= {wrLog[27:0], 2'b00, arrWrSeg};
      end
      if (arrRdEn) rdCnt <= rdCnt + 1;
    end
  end

  always_comb begin
    for (int s = 0; s < NSEG; s++) arrRdData[s*SW +: SW] = mem[arrRow][s];
  end

  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, int row, int seg, logic [SW-1:0] data);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = op;
    reqRow   = ROW_W'(row);
    reqSeg   = 2'(seg);
    reqData  = data;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // counts busy cycles from the first falling edge after acceptance
  task automatic busyLen(output int c, output bit rdyOk);
    c = 0;
    rdyOk = 1;
    @(negedge clk);
    while (busy) begin
      if (reqReady) rdyOk = 0;
      c++;
      @(negedge clk);
    end
  endtask

  task automatic openRowT(int r);
    int c;
    bit ok;
    send(2'd0, r, 0, '0);
    busyLen(c, ok);
    for (int s = 0; s < NSEG; s++) mdl[r][s] = mem[r][s];
  endtask

  function automatic int memMismatch();
    int n = 0;
    for (int r = 0; r < NROW; r++)
      for (int s = 0; s < NSEG; s++)
        if (mem[r][s] !== mdl[r][s]) n++;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    int c, w0, r0;
    bit ok;
    logic [SW-1:0] buffered [NSEG];
    logic [31:0] expLog;
    int pc;

    rst = 1'b1;
    bypassMode = 1'b0;
    reqValid = 1'b0;
    reqOp = '0; reqRow = '0; reqSeg = '0; reqData = '0;
    for (int r = 0; r < NROW; r++)
      for (int s = 0; s < NSEG; s++) mdl[r][s] = pat(r, s);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy", 64'(busy), 0);
    check("R1 reset rowOpen", 64'(rowOpen), 0);
    check("R3 reset segDirty", 64'(segDirty), 0);
    check("R10 reset ready", 64'(reqReady), 1);

    // R2: requests with no open row are dropped
    send(2'd1, 0, 1, '0);
    @(negedge clk);
    check("R2 read no row rspValid", 64'(rspValid), 0);
    send(2'd2, 0, 2, 16'hDEAD);
    @(negedge clk);
    check("R2 write no row segDirty", 64'(segDirty), 0);
    check("R2 write no row arrWr", 64'(wrCnt), 0);

    // R1: activate timing
    r0 = rdCnt;
    send(2'd0, 6, 0, '0);
    @(negedge clk);
    check("R1 arrRdEn after accept", 64'(arrRdEn), 1);
    check("R1 arrRow", 64'(arrRow), 6);
    c = 1;
    while (busy) begin @(negedge clk); if (busy) c++; end
    check("R1 fill busy length", 64'(c), RDL);
    check("R1 row open", 64'(rowOpen), 1);
    check("R1 open row index", 64'(openRow), 6);
    check("R1 single array read", 64'(rdCnt - r0), 1);
    check("R1 no array write", 64'(wrCnt), 0);
    send(2'd1, 0, 2, '0);
    @(negedge clk);
    check("R2 read valid", 64'(rspValid), 1);
    check("R2 read data", 64'(rspData), 64'(pat(6, 2)));
    check("R2 write seg 2 was dropped", 64'(rspData == 16'hDEAD), 0);
    send(2'd3, 0, 0, '0);

    // R3 R4 R5 R6 R7: every dirty pattern of a four-segment row
    for (int m = 0; m < 16; m++) begin
      int r;
      r = m % NROW;
      openRowT(r);
      for (int s = 0; s < NSEG; s++) buffered[s] = mdl[r][s];
      pc = 0;
      expLog = '0;
      for (int s = 0; s < NSEG; s++) begin
        if (m[s]) begin
          buffered[s] = SW'(m * 37 + s * 5 + 16'h0400);
          send(2'd2, 0, s, buffered[s]);
          pc++;
          expLog = {expLog[27:0], 4'(s)};
        end
      end
      @(negedge clk);
      check("R3 segDirty pattern", 64'(segDirty), 64'(m));
      check("R4 rowDirty", 64'(rowDirty), 64'(m != 0));
      for (int s = 0; s < NSEG; s++) begin
        send(2'd1, 0, s, '0);
        @(negedge clk);
        check("R2 R3 buffered read", 64'(rspValid ? rspData : 16'hFFFF), 64'(buffered[s]));
      end
      w0 = wrCnt;
      send(2'd3, 0, 0, '0);
      busyLen(c, ok);
      check("R7 writeback busy length", 64'(c), 64'(pc * WRL));
      check("R10 ready low while busy", 64'(ok), 1);
      check("R6 one write per dirty seg", 64'(wrCnt - w0), 64'(pc));
      if (pc > 0) check("R6 ascending order", 64'(wrLog & ((pc == 4) ? 32'hFFFF : (32'h1 << (4*pc)) - 1)), 64'(expLog));
      if (pc == 0) check("R5 clean close no write", 64'(wrCnt - w0), 0);
      check("R5 R7 row closed", 64'(rowOpen), 0);
      check("R7 dirty cleared", 64'(segDirty), 0);
      for (int s = 0; s < NSEG; s++) if (m[s]) mdl[r][s] = buffered[s];
      check("R6 array contents", 64'(memMismatch()), 0);
    end

    // R6: first write pulse timing
    openRowT(3);
    send(2'd2, 0, 3, 16'h3333);
    send(2'd3, 0, 0, '0);
    @(negedge clk);
    check("R6 arrWrEn after accept", 64'(arrWrEn), 1);
    check("R6 arrWrSeg", 64'(arrWrSeg), 3);
    check("R6 arrWrData", 64'(arrWrData), 64'(16'h3333));
    while (busy) @(negedge clk);
    mdl[3][3] = 16'h3333;

    // R9: bypass hit on a dirty segment
    openRowT(2);
    send(2'd2, 0, 1, 16'h1111);
    bypassMode = 1'b1;
    w0 = wrCnt;
    send(2'd2, 2, 1, 16'hB0B1);
    @(negedge clk);
    check("R9 bypass arrWrEn", 64'(arrWrEn), 1);
    check("R9 bypass arrRow", 64'(arrRow), 2);
    check("R9 bypass hit clears dirty", 64'(segDirty), 0);
    c = 1;
    while (busy) begin @(negedge clk); if (busy) c++; end
    check("R9 bypass busy length", 64'(c), WRL);
    mdl[2][1] = 16'hB0B1;
    send(2'd1, 0, 1, '0);
    @(negedge clk);
    check("R9 hit updates buffer", 64'(rspData), 64'(16'hB0B1));
    // bypass miss: array only
    send(2'd2, 5, 3, 16'hC5C3);
    @(negedge clk);
    while (busy) @(negedge clk);
    mdl[5][3] = 16'hC5C3;
    send(2'd1, 0, 3, '0);
    @(negedge clk);
    check("R9 miss leaves buffer", 64'(rspData), 64'(mdl[2][3]));
    check("R9 miss no dirty", 64'(segDirty), 0);
    check("R9 bypass array writes", 64'(wrCnt - w0), 2);
    check("R9 array contents", 64'(memMismatch()), 0);
    w0 = wrCnt;
    send(2'd3, 0, 0, '0);
    @(negedge clk);
    check("R5 clean close after bypass", 64'(wrCnt - w0), 0);
    bypassMode = 1'b0;

    // R8: activate on a dirty row drains first
    openRowT(1);
    send(2'd2, 0, 0, 16'h1A00);
    send(2'd2, 0, 2, 16'h1A02);
    w0 = wrCnt;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqRow = 3'd4;
    #1;
    check("R8 activate held off", 64'(reqReady), 0);
    while (!reqReady) @(negedge clk);
    check("R8 drained before accept", 64'(wrCnt - w0), 2);
    check("R8 dirty clear at accept", 64'(segDirty), 0);
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    mdl[1][0] = 16'h1A00;
    mdl[1][2] = 16'h1A02;
    check("R8 new row open", 64'(openRow), 4);
    check("R8 row open flag", 64'(rowOpen), 1);
    check("R8 array contents", 64'(memMismatch()), 0);
    send(2'd1, 0, 0, '0);
    @(negedge clk);
    check("R8 new row data", 64'(rspData), 64'(mdl[4][0]));

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule